// File: doc/BRIEF.md
# Ultraviolet-Erasable Byte Memory Model

This block is a synthesizable, clocked stand-in for a byte-wide ultraviolet-erasable programmable memory. It decodes three active-low control inputs (chip select, output gate and program strobe) and two digital flags into a set of operating modes: standby, program inhibit, output off, read, program verify, program and identification readout. Analog supply levels are reduced to flags. One flag says the programming supply is raised. Another says an identification voltage is present on the address line. Tri-state output is modelled as a data bus plus a drive-enable, and the bus reads zero whenever it is not driven.

Programming can only clear bits. A clean program pulse ANDs the presented byte into the addressed word on the pulse's rising edge. The only way back to ones is a bulk erase, which sweeps the whole array to all-ones one word per clock and then pulses a done flag. Reset starts the same sweep. If the program strobe is held low too long, a fault is raised and that pulse is discarded. When the identification flag is set, a read returns a two-byte identification code instead of array data.

Top module: `uv_prom_model`

## Requirements
- R1: After reset, and after every bulk erase, every word reads as all ones (0xFF).
- R2: A valid program pulse replaces the addressed word with (old word AND presented byte), so no bit ever goes from 0 to 1 through programming.
- R3: With chip select high (ce_n = 1), dout_en is 0, dout is 0 and no program pulse changes the array, whatever the other inputs are.
- R4: With ce_n = 0, oe_n = 0, pgm_n = 1 and id_hv = 0, dout_en is 1 and dout shows the addressed word, both with vpp_hi low (read) and with vpp_hi high (verify).
- R5: With ce_n = 0, oe_n = 1 and pgm_n = 1, dout_en is 0 and dout is 0.
- R6: A write happens only if vpp_hi = 1, ce_n = 0 and oe_n = 1 hold on every clock edge of the strobe-low interval. The write lands on the edge where pgm_n is first seen high again. A pulse with vpp_hi low writes nothing, and the outputs are off while programming.
- R7: With id_hv = 1, ce_n = 0, oe_n = 0 and pgm_n = 1, dout_en is 1 and dout is 0x8F when address bit 0 is 0, or 0xC2 when it is 1, regardless of array contents.
- R8: strobe_fault is 1 once pgm_n has been sampled low on PULSE_LIMIT consecutive clock edges, and 0 one edge earlier. A pulse that reaches PULSE_LIMIT low edges writes nothing. A pulse of PULSE_LIMIT-1 low edges writes normally.
- R9: erase_req sampled high while idle starts a sweep. erase_done pulses high for exactly one cycle after the DEPTH-th following edge. Program pulses that end during the sweep are discarded.
- R10: pgm_n low with chip select low but without the full program condition (vpp_hi low or oe_n low) is an illegal combination: outputs are off and nothing is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Model clock |
| rst_n | input | 1 | Asynchronous active-low reset; starts an erase sweep |
| addr | input | ADDR_W | Word address |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| pgm_n | input | 1 | Program strobe, active low |
| din | input | DATA_W | Byte presented for programming |
| vpp_hi | input | 1 | Programming supply raised |
| id_hv | input | 1 | Identification voltage present |
| erase_req | input | 1 | Bulk erase request |
| dout | output | DATA_W | Output data, zero when not driven |
| dout_en | output | 1 | Output drive enable |
| erase_busy | output | 1 | Erase sweep in progress |
| erase_done | output | 1 | One-cycle pulse at the end of a sweep |
| strobe_fault | output | 1 | Program strobe held low too long |

## Verification
The hardest conditions to reach are the strobe-length boundary and a program pulse that ends in the middle of an erase sweep. The first needs a pulse held for exactly PULSE_LIMIT-1 or exactly PULSE_LIMIT edges. The second needs a pulse timed to end after the sweep pointer has already passed the target word. Directed tasks produce both with exact edge counts. Constrained-random operations from a seeded $urandom stream then mix program, read, verify, inhibit, illegal and identification cycles against a bench-side AND-only reference array.

// File: rtl/uvprom_pkg.sv
package uvprom_pkg;

   typedef enum logic [2:0] {
      MD_STANDBY,
      MD_INHIBIT,
      MD_OFF,
      MD_READ,
      MD_VERIFY,
      MD_PROGRAM,
      MD_IDENT,
      MD_ILLEGAL
   } prom_mode_e;

   // Priority: chip select, then strobe, then output gate, then ident flag.
   function automatic prom_mode_e decode_mode(input logic ce_n, input logic oe_n,
                                              input logic pgm_n, input logic vpp_hi,
                                              input logic id_hv);
      if (ce_n)   return vpp_hi ? MD_INHIBIT : MD_STANDBY;
      if (!pgm_n) return (vpp_hi && oe_n) ? MD_PROGRAM : MD_ILLEGAL;
      if (oe_n)   return MD_OFF;
      if (id_hv)  return MD_IDENT;
      return vpp_hi ? MD_VERIFY : MD_READ;
   endfunction

   function automatic logic mode_drives(input prom_mode_e m);
      return (m == MD_READ) || (m == MD_VERIFY) || (m == MD_IDENT);
   endfunction

endpackage

// File: rtl/prom_mode_decode.sv
module prom_mode_decode
   import uvprom_pkg::*;
(
   input  logic       ce_n,
   input  logic       oe_n,
   input  logic       pgm_n,
   input  logic       vpp_hi,
   input  logic       id_hv,
   output prom_mode_e mode,
   output logic       drive,
   output logic       prog_cond
);
   always_comb begin
      mode      = decode_mode(ce_n, oe_n, pgm_n, vpp_hi, id_hv);
      drive     = mode_drives(mode);
      prog_cond = !ce_n && oe_n && vpp_hi;
   end
endmodule

// File: rtl/prom_strobe_mon.sv
module prom_strobe_mon #(
   parameter int ADDR_W      = 10,
   parameter int DATA_W      = 8,
   parameter int PULSE_LIMIT = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pgm_n,
   input  logic              prog_cond,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic              fire,
   output logic [ADDR_W-1:0] fire_addr,
   output logic [DATA_W-1:0] fire_data,
   output logic              fault
);
   localparam int CW = $clog2(PULSE_LIMIT + 1);
   localparam logic [CW-1:0] LIM = CW'(PULSE_LIMIT);

   logic [CW-1:0] low_cnt;
   logic          armed;

   generate
      if (PULSE_LIMIT < 2) begin : g_lim_bad
         $error("PULSE_LIMIT must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt   <= '0;
         armed     <= 1'b0;
         fire_addr <= '0;
         fire_data <= '0;
      end else if (!pgm_n) begin
         if (low_cnt != LIM) low_cnt <= low_cnt + 1'b1;
         // Armed only if the program condition held on every low edge.
         armed <= prog_cond && (armed || (low_cnt == '0));
         if (prog_cond) begin
            fire_addr <= addr;
            fire_data <= din;
         end
      end else begin
         low_cnt <= '0;
         armed   <= 1'b0;
      end
   end

   assign fault = (low_cnt >= LIM);
   assign fire  = pgm_n && armed && (low_cnt < LIM);

   // R8
   long_pulse_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pgm_n && fault) |=> !fire);
   // R6
   fire_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> ($past(!pgm_n) && $past(prog_cond)));
endmodule

// File: rtl/prom_array.sv
module prom_array #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              erase_req,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_mask,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              busy,
   output logic              done
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);
   localparam logic [DATA_W-1:0] BLANK = '1;

   logic [DATA_W-1:0] mem [DEPTH];
   logic [ADDR_W-1:0] ptr;
   logic              we;
   logic [ADDR_W-1:0] wa;
   logic [DATA_W-1:0] wd;
   logic [DATA_W-1:0] old_word;

   generate
      if (ADDR_W > 12) begin : g_depth_bad
         $error("ADDR_W above 12 makes the array too large for this model");
      end
   endgenerate

   always_comb begin
      old_word = mem[wr_addr];
      we       = busy || wr_en;
      wa       = busy ? ptr : wr_addr;
      wd       = busy ? BLANK : (old_word & wr_mask);
   end

   always_ff @(posedge clk) begin
      if (we) mem[wa] <= wd;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b1;
         ptr  <= '0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (busy) begin
            ptr <= ptr + 1'b1;
            if (ptr == LAST) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end else if (erase_req) begin
            busy <= 1'b1;
            ptr  <= '0;
         end
      end
   end

   assign rd_data = mem[rd_addr];

   // R2
   and_only_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !busy) |=> ((mem[$past(wr_addr)] & ~$past(old_word)) == '0));
   // R9
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R9
   sweep_progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (busy || done));
endmodule

// File: rtl/uv_prom_model.sv
module uv_prom_model
   import uvprom_pkg::*;
#(
   parameter int          ADDR_W      = 10,
   parameter int          DATA_W      = 8,
   parameter int          PULSE_LIMIT = 16,
   parameter int          ID_SEL_BIT  = 0,
   parameter logic [7:0]  ID_MAKER    = 8'h8F,
   parameter logic [7:0]  ID_PART     = 8'hC2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              pgm_n,
   input  logic [DATA_W-1:0] din,
   input  logic              vpp_hi,
   input  logic              id_hv,
   input  logic              erase_req,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en,
   output logic              erase_busy,
   output logic              erase_done,
   output logic              strobe_fault
);
   prom_mode_e        mode;
   logic              drive;
   logic              prog_cond;
   logic              fire;
   logic [ADDR_W-1:0] fire_addr;
   logic [DATA_W-1:0] fire_data;
   logic [DATA_W-1:0] rd_data;
   logic [DATA_W-1:0] id_byte;

   generate
      if (ID_SEL_BIT >= ADDR_W) begin : g_idsel_bad
         $error("ID_SEL_BIT must select an existing address bit");
      end
      if (DATA_W >= 8) begin : g_id_wide
         assign id_byte = DATA_W'(addr[ID_SEL_BIT] ? ID_PART : ID_MAKER);
      end else begin : g_id_narrow
         assign id_byte = addr[ID_SEL_BIT] ? ID_PART[DATA_W-1:0] : ID_MAKER[DATA_W-1:0];
      end
   endgenerate

   prom_mode_decode i_dec (
      .ce_n      (ce_n),
      .oe_n      (oe_n),
      .pgm_n     (pgm_n),
      .vpp_hi    (vpp_hi),
      .id_hv     (id_hv),
      .mode      (mode),
      .drive     (drive),
      .prog_cond (prog_cond)
   );

   prom_strobe_mon #(
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .PULSE_LIMIT (PULSE_LIMIT)
   ) i_strobe (
      .clk       (clk),
      .rst_n     (rst_n),
      .pgm_n     (pgm_n),
      .prog_cond (prog_cond),
      .addr      (addr),
      .din       (din),
      .fire      (fire),
      .fire_addr (fire_addr),
      .fire_data (fire_data),
      .fault     (strobe_fault)
   );

   prom_array #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) i_array (
      .clk       (clk),
      .rst_n     (rst_n),
      .erase_req (erase_req),
      .wr_en     (fire),
      .wr_addr   (fire_addr),
      .wr_mask   (fire_data),
      .rd_addr   (addr),
      .rd_data   (rd_data),
      .busy      (erase_busy),
      .done      (erase_done)
   );

   always_comb begin
      dout_en = drive;
      if (!drive)                dout = '0;
      else if (mode == MD_IDENT) dout = id_byte;
      else                       dout = rd_data;
   end

   // R3
   standby_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ce_n |-> (!dout_en && dout == '0));
   // R5
   gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && oe_n) |-> !dout_en);
   // R7
   ident_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (id_hv && !ce_n && !oe_n && pgm_n) |->
         (dout_en && dout == DATA_W'(addr[ID_SEL_BIT] ? ID_PART : ID_MAKER)));
   // R10
   illegal_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pgm_n && (!vpp_hi || !oe_n)) |-> !dout_en);
endmodule

// File: tb/test_uv_prom_model.sv
module test_uv_prom_model;
   localparam int AW = 10;
   localparam int DW = 8;
   localparam int DEPTH = 1 << AW;
   localparam int LIMIT = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1;
   logic [DW-1:0] din = '0;
   logic          vpp_hi = 1'b0, id_hv = 1'b0, erase_req = 1'b0;
   logic [DW-1:0] dout;
   logic          dout_en, erase_busy, erase_done, strobe_fault;

   logic [DW-1:0] ref_mem [DEPTH];
   int n_cmp = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   uv_prom_model #(.ADDR_W(AW), .DATA_W(DW), .PULSE_LIMIT(LIMIT)) i_uv_prom_model (
      .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
      .din(din), .vpp_hi(vpp_hi), .id_hv(id_hv), .erase_req(erase_req),
      .dout(dout), .dout_en(dout_en), .erase_busy(erase_busy),
      .erase_done(erase_done), .strobe_fault(strobe_fault));

   function automatic logic [DW-1:0] exp_ident(input logic a0);
      return a0 ? 8'hC2 : 8'h8F;
   endfunction

   function automatic logic [DW-1:0] exp_prog(input logic [DW-1:0] old_w, input logic [DW-1:0] d);
      return old_w & d;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) begin @(posedge clk); #2; end
   endtask

   task automatic idle();
      ce_n = 1'b1; oe_n = 1'b1; pgm_n = 1'b1; vpp_hi = 1'b0; id_hv = 1'b0; erase_req = 1'b0;
   endtask

   task automatic rd_check(input string req, input logic [AW-1:0] a, input logic vpp);
      ce_n = 1'b0; oe_n = 1'b0; pgm_n = 1'b1; vpp_hi = vpp; id_hv = 1'b0; addr = a;
      #1;
      check(req, {dout_en, 23'd0, dout}, {1'b1, 23'd0, ref_mem[a]});
      cyc(1);
      idle();
   endtask

   task automatic pulse(input logic [AW-1:0] a, input logic [DW-1:0] d, input int len,
                        input logic vpp, input logic ce, input logic oe, input logic writes);
      addr = a; din = d; vpp_hi = vpp; ce_n = ce; oe_n = oe; id_hv = 1'b0; pgm_n = 1'b0;
      #1;
      check("R6/R10 outputs off while strobe low", {31'd0, dout_en}, 32'd0);
      cyc(len);
      pgm_n = 1'b1;
      cyc(1);
      if (writes) ref_mem[a] = exp_prog(ref_mem[a], d);
      idle();
   endtask

   task automatic wait_done(input string req, input logic timed);
      int k;
      k = 0;
      while (!erase_done && k < DEPTH + 8) begin cyc(1); k++; end
      if (timed) check(req, k, DEPTH);
      else check(req, {31'd0, erase_done}, 32'd1);
      cyc(1);
      check("R9 done one cycle", {31'd0, erase_done}, 32'd0);
      for (int i = 0; i < DEPTH; i++) ref_mem[i] = '1;
   endtask

   initial begin
      #(8 * 150000);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      void'($urandom(32'd20240611));
      idle();
      #1;
      check("R3 reset outputs off", {31'd0, dout_en}, 32'd0);
      cyc(2);
      rst_n = 1'b1;
      // R1: reset sweep; release then DEPTH edges to done
      wait_done("R1 reset sweep length", 1'b1);
      for (int i = 0; i < 12; i++) rd_check("R1 blank after reset", AW'($urandom), 1'b0);
      rd_check("R1 blank last word", AW'(DEPTH - 1), 1'b0);

      // R2: program then overwrite with ones where zeros stored
      pulse(AW'(5), 8'hA5, 3, 1'b1, 1'b0, 1'b1, 1'b1);
      rd_check("R2 programmed word", AW'(5), 1'b0);
      pulse(AW'(5), 8'h5F, 3, 1'b1, 1'b0, 1'b1, 1'b1);
      rd_check("R2 AND accumulate", AW'(5), 1'b0);
      check("R2 exact value", {24'd0, ref_mem[5]}, 32'h05);
      // R4 verify mode with vpp high
      rd_check("R4 verify with vpp high", AW'(5), 1'b1);

      // R3 inhibit: chip select high, pulse does nothing
      for (int i = 0; i < 4; i++) begin
         ce_n = 1'b1; oe_n = 1'($urandom); pgm_n = 1'($urandom); vpp_hi = 1'($urandom);
         id_hv = 1'($urandom); addr = AW'($urandom);
         #1;
         check("R3 standby outputs", {dout_en, 23'd0, dout}, 32'd0);
         cyc(1);
      end
      idle();
      pulse(AW'(9), 8'h00, 3, 1'b1, 1'b1, 1'b1, 1'b0);
      rd_check("R3 inhibit no write", AW'(9), 1'b0);

      // R5 output off
      ce_n = 1'b0; oe_n = 1'b1; pgm_n = 1'b1; addr = AW'(5); #1;
      check("R5 output disable", {dout_en, 23'd0, dout}, 32'd0);
      cyc(1); idle();

      // R6 vpp low: no write; R10 oe low: no write
      pulse(AW'(11), 8'h00, 3, 1'b0, 1'b0, 1'b1, 1'b0);
      rd_check("R6 vpp low no write", AW'(11), 1'b0);
      pulse(AW'(12), 8'h00, 3, 1'b1, 1'b0, 1'b0, 1'b0);
      rd_check("R10 oe low no write", AW'(12), 1'b0);

      // R7 identification over non-blank words
      pulse(AW'(0), 8'h12, 2, 1'b1, 1'b0, 1'b1, 1'b1);
      pulse(AW'(1), 8'h34, 2, 1'b1, 1'b0, 1'b1, 1'b1);
      for (int b = 0; b < 2; b++) begin
         ce_n = 1'b0; oe_n = 1'b0; pgm_n = 1'b1; id_hv = 1'b1; addr = AW'(b); #1;
         check("R7 ident byte", {dout_en, 23'd0, dout}, {1'b1, 23'd0, exp_ident(b[0])});
         cyc(1);
      end
      idle();
      rd_check("R7 array intact", AW'(1), 1'b0);

      // R8 fault boundary
      addr = AW'(20); din = 8'h0F; vpp_hi = 1'b1; ce_n = 1'b0; oe_n = 1'b1; pgm_n = 1'b0;
      cyc(LIMIT - 1);
      check("R8 no fault at limit-1", {31'd0, strobe_fault}, 32'd0);
      cyc(1);
      check("R8 fault at limit", {31'd0, strobe_fault}, 32'd1);
      pgm_n = 1'b1; cyc(1); idle();
      rd_check("R8 long pulse no write", AW'(20), 1'b0);
      pulse(AW'(21), 8'h0F, LIMIT - 1, 1'b1, 1'b0, 1'b1, 1'b1);
      rd_check("R8 limit-1 pulse writes", AW'(21), 1'b0);

      // R9 erase timing and program inside sweep
      erase_req = 1'b1; cyc(1); erase_req = 1'b0;
      wait_done("R9 sweep length", 1'b1);
      rd_check("R9 erased word", AW'(5), 1'b0);
      rd_check("R9 erased word", AW'(21), 1'b0);
      erase_req = 1'b1; cyc(1); erase_req = 1'b0;
      cyc(6);
      pulse(AW'(2), 8'h00, 3, 1'b1, 1'b0, 1'b1, 1'b0);
      wait_done("R9 second sweep", 1'b0);
      rd_check("R9 program during sweep discarded", AW'(2), 1'b0);

      // Random mix
      for (int it = 0; it < 150; it++) begin
         a = AW'($urandom_range(0, 31));
         d = DW'($urandom);
         case ($urandom_range(0, 4))
            0, 1: pulse(a, d, $urandom_range(1, 5), 1'b1, 1'b0, 1'b1, 1'b1);
            2:    pulse(a, d, 2, 1'b1, 1'b1, 1'($urandom), 1'b0);
            3:    pulse(a, d, 2, 1'b0, 1'b0, 1'($urandom), 1'b0);
            default: begin
               ce_n = 1'b0; oe_n = 1'b0; pgm_n = 1'b1; id_hv = 1'b1; addr = a; #1;
               check("R7 random ident", {24'd0, dout}, {24'd0, exp_ident(a[0])});
               cyc(1); idle();
            end
         endcase
         rd_check("R2/R4 random read", a, 1'($urandom));
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule